// File: doc/BRIEF.md
# Nested Trap State Stack

This block keeps the processor state that must survive a trap and come back on return, for traps nested up to a parameterised depth. When a trap command is accepted, the current condition codes, address-space identifier, processor-state word and window pointer are packed into a single state word for the current level. The block stores that word together with the current PC, next PC and trap type. It then forms the handler entry state and advances the trap level. The entry state is the forced processor-state word, the new low bits of the trap-base register, and the handler PC and next PC.

A return command pops one level and replays the saved state. It comes in two forms:
- The default form resumes after the trapped instruction.
- The retry form re-executes the trapped instruction.

A trap taken while the level is already at its maximum puts the block into a sticky error state. A return with nothing on the stack is reported as illegal.

Commands arrive on a valid/ready interface, and results leave on a second valid/ready interface. A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while an unconsumed result is held with `rsp_ready` low, and it stays low for good once the error state has been entered. A result appears one cycle after its command is accepted. It stays stable until it is taken. Level, trap-base low bits, top trap type and error status are plain outputs.

Top module: `trap_state_stack`

## Requirements
- R1: After reset, `trap_lvl` is 0, `err_state` is 0, `rsp_valid` is 0, `tba_low` is 0, `top_tt` is 0 and `cmd_ready` is 1.
- R2: A trap saves the state word {ccr in bits 39:32, asi in bits 31:24, zero in bits 23:20, pst in bits 19:8, cwp in bits 7:0}. A later return that pops that level gives back exactly the ccr, asi, pst and cwp that were present at the trap.
- R3: The result of an accepted trap carries pst = 0x015, which is bits 0 (alternate globals), 2 (privileged) and 4 (FP enabled). Bit 5 (red state) is added, giving 0x035, when the trap is taken at level MAX_LVL-1. ccr, asi and cwp pass through unchanged.
- R4: An accepted trap loads `tba_low` with {bit 14 = (level before the trap > 1), bits 13:5 = trap type, bits 4:0 = 0}. The result PC is {tba_base, new tba_low} and the result next PC is that value plus 4.
- R5: Each accepted trap taken below MAX_LVL raises `trap_lvl` by one.
- R6: A trap command accepted at level MAX_LVL sets `err_state`, which then stays set until reset. It produces no result and leaves `trap_lvl` unchanged, and `cmd_ready` stays 0 from then on.
- R7: A default return (`cmd_retry`=0) at a non-zero level lowers `trap_lvl` by one. Its result PC is the saved next PC of the popped level, and its result next PC is that value plus 4.
- R8: A retry return (`cmd_retry`=1) lowers `trap_lvl` by one. Its result PC is the saved PC and its result next PC is the saved next PC of the popped level.
- R9: A return accepted at level 0 produces a result with `rsp_illegal`=1 and leaves `trap_lvl` at 0.
- R10: While `rsp_valid` is 1 and `rsp_ready` is 0, the result is held stable, `cmd_ready` is 0, and no command changes `trap_lvl`.
- R11: `top_tt` shows the trap type saved at level `trap_lvl`-1, and shows 0 when `trap_lvl` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_ret | input | 1 | 1 = return, 0 = trap |
| cmd_retry | input | 1 | Return form: 1 = re-execute, 0 = resume after |
| cmd_tt | input | 9 | Trap type for a trap command |
| cur_ccr | input | 8 | Current condition codes |
| cur_asi | input | 8 | Current address-space identifier |
| cur_pst | input | 12 | Current processor-state word |
| cur_cwp | input | 8 | Current window pointer |
| cur_pc | input | PC_W | Current PC |
| cur_npc | input | PC_W | Current next PC |
| tba_base | input | PC_W-15 | Upper bits of the trap-base register |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_valid | output | 1 | Result present |
| rsp_illegal | output | 1 | Result is an illegal return at level 0 |
| rsp_pc | output | PC_W | New PC |
| rsp_npc | output | PC_W | New next PC |
| rsp_ccr | output | 8 | New condition codes |
| rsp_asi | output | 8 | New address-space identifier |
| rsp_pst | output | 12 | New processor-state word |
| rsp_cwp | output | 8 | New window pointer |
| trap_lvl | output | TL_W | Current trap level |
| tba_low | output | 15 | Low bits of the trap-base register |
| top_tt | output | 9 | Trap type of the newest saved level |
| err_state | output | 1 | Sticky error: trap taken at maximum level |

## Verification
A stale or wrongly indexed level in the store shows up on the first return that pops it. The result one cycle later carries the wrong PC, next PC or restored fields, and `top_tt` already shows the wrong trap type in the cycle after the push. A wrong level count shows on `trap_lvl` in the cycle after the command. It also shows in the nested-level bit of `tba_low` and in the red-state bit of the next trap result. Unwinding the full stack in both return forms therefore exposes a fault within a single command.

// File: rtl/tstk_pkg.sv
package tstk_pkg;
  localparam int CCR_W  = 8;
  localparam int ASI_W  = 8;
  localparam int PST_W  = 12;
  localparam int CWP_W  = 8;
  localparam int TT_W   = 9;
  localparam int VEC_W  = 15;
  localparam int WORD_W = 32 + CCR_W;

  localparam int PST_AG   = 0;
  localparam int PST_PRIV = 2;
  localparam int PST_PEF  = 4;
  localparam int PST_RED  = 5;

  typedef struct packed {
    logic [CCR_W-1:0] ccr;
    logic [ASI_W-1:0] asi;
    logic [PST_W-1:0] pst;
    logic [CWP_W-1:0] cwp;
  } arch_t;
endpackage

// File: rtl/tstk_codec.sv
module tstk_codec
  import tstk_pkg::*;
(
  input  arch_t             pk_in,
  output logic [WORD_W-1:0] pk_word,
  input  logic [WORD_W-1:0] up_word,
  output arch_t             up_out
);
  assign pk_word = {pk_in.ccr, pk_in.asi, 4'b0000, pk_in.pst, pk_in.cwp};

  assign up_out.ccr = up_word[WORD_W-1:32];
  assign up_out.asi = up_word[31:24];
  assign up_out.pst = up_word[19:8];
  assign up_out.cwp = up_word[7:0];

  logic unused_rsvd;
  assign unused_rsvd = ^up_word[23:20];
endmodule

// File: rtl/tstk_store.sv
module tstk_store
  import tstk_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int IDX_W = 3,
  parameter int PC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [PC_W-1:0]   wr_pc,
  input  logic [PC_W-1:0]   wr_npc,
  input  logic [TT_W-1:0]   wr_tt,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [PC_W-1:0]   rd_pc,
  output logic [PC_W-1:0]   rd_npc,
  output logic [TT_W-1:0]   rd_tt
);
  logic [WORD_W-1:0] word_q [DEPTH];
  logic [PC_W-1:0]   pc_q   [DEPTH];
  logic [PC_W-1:0]   npc_q  [DEPTH];
  logic [TT_W-1:0]   tt_q   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q[g] <= '0;
        pc_q[g]   <= '0;
        npc_q[g]  <= '0;
        tt_q[g]   <= '0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        word_q[g] <= wr_word;
        pc_q[g]   <= wr_pc;
        npc_q[g]  <= wr_npc;
        tt_q[g]   <= wr_tt;
      end
    end
  end

  always_comb begin
    rd_word = '0;
    rd_pc   = '0;
    rd_npc  = '0;
    rd_tt   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (rd_idx == IDX_W'(i)) begin
        rd_word = word_q[i];
        rd_pc   = pc_q[i];
        rd_npc  = npc_q[i];
        rd_tt   = tt_q[i];
      end
    end
  end
endmodule

// File: rtl/tstk_vector.sv
module tstk_vector
  import tstk_pkg::*;
#(
  parameter int MAX_LVL = 4,
  parameter int TL_W    = 3,
  parameter int PC_W    = 32
) (
  input  logic [TL_W-1:0]      lvl,
  input  logic [TT_W-1:0]      tt,
  input  logic [PC_W-VEC_W-1:0] base,
  output logic [VEC_W-1:0]     vec_low,
  output logic [PC_W-1:0]      ent_pc,
  output logic [PC_W-1:0]      ent_npc,
  output logic [PST_W-1:0]     ent_pst
);
  localparam logic [PST_W-1:0] PST_ENTRY =
    PST_W'((1 << PST_AG) | (1 << PST_PRIV) | (1 << PST_PEF));

  always_comb begin
    vec_low = {(lvl > TL_W'(1)), tt, 5'b00000};
    ent_pc  = {base, vec_low};
    ent_npc = ent_pc + PC_W'(4);
    ent_pst = PST_ENTRY;
    if (lvl == TL_W'(MAX_LVL - 1)) ent_pst[PST_RED] = 1'b1;
  end
endmodule

// File: rtl/trap_state_stack.sv
module trap_state_stack
  import tstk_pkg::*;
#(
  parameter int MAX_LVL = 4,
  parameter int PC_W    = 32,
  localparam int TL_W   = $clog2(MAX_LVL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_ret,
  input  logic                 cmd_retry,
  input  logic [TT_W-1:0]      cmd_tt,
  input  logic [CCR_W-1:0]     cur_ccr,
  input  logic [ASI_W-1:0]     cur_asi,
  input  logic [PST_W-1:0]     cur_pst,
  input  logic [CWP_W-1:0]     cur_cwp,
  input  logic [PC_W-1:0]      cur_pc,
  input  logic [PC_W-1:0]      cur_npc,
  input  logic [PC_W-VEC_W-1:0] tba_base,
  input  logic                 rsp_ready,
  output logic                 rsp_valid,
  output logic                 rsp_illegal,
  output logic [PC_W-1:0]      rsp_pc,
  output logic [PC_W-1:0]      rsp_npc,
  output logic [CCR_W-1:0]     rsp_ccr,
  output logic [ASI_W-1:0]     rsp_asi,
  output logic [PST_W-1:0]     rsp_pst,
  output logic [CWP_W-1:0]     rsp_cwp,
  output logic [TL_W-1:0]      trap_lvl,
  output logic [VEC_W-1:0]     tba_low,
  output logic [TT_W-1:0]      top_tt,
  output logic                 err_state
);
  logic [TL_W-1:0]  tl_q;
  logic [VEC_W-1:0] vec_q;
  logic             err_q;
  logic             vld_q, ill_q;
  logic [PC_W-1:0]  pc_q, npc_q;
  arch_t            st_q;

  logic accept, at_max, at_zero, do_trap, do_err, do_pop, do_ill;
  logic [TL_W-1:0] top_idx;

  assign cmd_ready = !err_q && (!vld_q || rsp_ready);
  assign accept    = cmd_valid && cmd_ready;
  assign at_max    = tl_q == TL_W'(MAX_LVL);
  assign at_zero   = tl_q == '0;
  assign do_trap   = accept && !cmd_ret && !at_max;
  assign do_err    = accept && !cmd_ret && at_max;
  assign do_pop    = accept && cmd_ret && !at_zero;
  assign do_ill    = accept && cmd_ret && at_zero;
  assign top_idx   = tl_q - TL_W'(1);

  arch_t             cur_st, pop_st;
  logic [WORD_W-1:0] pk_word, rd_word;
  logic [PC_W-1:0]   rd_pc, rd_npc, ent_pc, ent_npc;
  logic [TT_W-1:0]   rd_tt;
  logic [VEC_W-1:0]  vec_new;
  logic [PST_W-1:0]  ent_pst;

  assign cur_st = '{ccr: cur_ccr, asi: cur_asi, pst: cur_pst, cwp: cur_cwp};

  tstk_codec u_codec (
    .pk_in   (cur_st),
    .pk_word (pk_word),
    .up_word (rd_word),
    .up_out  (pop_st)
  );

  tstk_store #(.DEPTH(MAX_LVL), .IDX_W(TL_W), .PC_W(PC_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (do_trap),
    .wr_idx  (tl_q),
    .wr_word (pk_word),
    .wr_pc   (cur_pc),
    .wr_npc  (cur_npc),
    .wr_tt   (cmd_tt),
    .rd_idx  (top_idx),
    .rd_word (rd_word),
    .rd_pc   (rd_pc),
    .rd_npc  (rd_npc),
    .rd_tt   (rd_tt)
  );

  tstk_vector #(.MAX_LVL(MAX_LVL), .TL_W(TL_W), .PC_W(PC_W)) u_vector (
    .lvl     (tl_q),
    .tt      (cmd_tt),
    .base    (tba_base),
    .vec_low (vec_new),
    .ent_pc  (ent_pc),
    .ent_npc (ent_npc),
    .ent_pst (ent_pst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tl_q  <= '0;
      vec_q <= '0;
      err_q <= 1'b0;
      vld_q <= 1'b0;
      ill_q <= 1'b0;
      pc_q  <= '0;
      npc_q <= '0;
      st_q  <= '0;
    end else begin
      if (vld_q && rsp_ready) vld_q <= 1'b0;
      if (do_err) err_q <= 1'b1;
      if (do_trap) begin
        tl_q   <= tl_q + TL_W'(1);
        vec_q  <= vec_new;
        vld_q  <= 1'b1;
        ill_q  <= 1'b0;
        pc_q   <= ent_pc;
        npc_q  <= ent_npc;
        st_q   <= '{ccr: cur_ccr, asi: cur_asi, pst: ent_pst, cwp: cur_cwp};
      end
      if (do_pop) begin
        tl_q  <= top_idx;
        vld_q <= 1'b1;
        ill_q <= 1'b0;
        pc_q  <= cmd_retry ? rd_pc : rd_npc;
        npc_q <= cmd_retry ? rd_npc : rd_npc + PC_W'(4);
        st_q  <= pop_st;
      end
      if (do_ill) begin
        vld_q <= 1'b1;
        ill_q <= 1'b1;
      end
    end
  end

  assign rsp_valid   = vld_q;
  assign rsp_illegal = ill_q;
  assign rsp_pc      = pc_q;
  assign rsp_npc     = npc_q;
  assign rsp_ccr     = st_q.ccr;
  assign rsp_asi     = st_q.asi;
  assign rsp_pst     = st_q.pst;
  assign rsp_cwp     = st_q.cwp;
  assign trap_lvl    = tl_q;
  assign tba_low     = vec_q;
  assign top_tt      = at_zero ? '0 : rd_tt;
  assign err_state   = err_q;
endmodule

// File: rtl/trap_state_stack_chk.sv
module trap_state_stack_chk
  import tstk_pkg::*;
#(
  parameter int MAX_LVL = 4,
  parameter int PC_W    = 32,
  parameter int TL_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_ret,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_illegal,
  input logic [PC_W-1:0]  rsp_pc,
  input logic [PST_W-1:0] rsp_pst,
  input logic [TL_W-1:0]  trap_lvl,
  input logic             err_state
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    trap_lvl <= TL_W'(MAX_LVL));

  a_r5_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmd_ret && trap_lvl != TL_W'(MAX_LVL)
    |=> trap_lvl == TL_W'($past(trap_lvl) + 1'b1));

  a_r3_entry_pst: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmd_ret && trap_lvl != TL_W'(MAX_LVL)
    |=> rsp_valid && rsp_pst[PST_PRIV] && rsp_pst[PST_PEF] && rsp_pst[PST_AG]);

  a_r3_red_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !cmd_ret && trap_lvl == TL_W'(MAX_LVL - 1) |=> rsp_pst[PST_RED]);

  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_state |=> err_state);

  a_r6_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    err_state |-> !cmd_ready);

  a_r7_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_ret && trap_lvl != '0
    |=> trap_lvl == TL_W'($past(trap_lvl) - 1'b1));

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cmd_ret && trap_lvl == '0 |=> rsp_illegal && trap_lvl == '0);

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_pc) && $stable(trap_lvl));
endmodule

bind trap_state_stack trap_state_stack_chk #(.MAX_LVL(MAX_LVL), .PC_W(PC_W), .TL_W(TL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_valid   (cmd_valid),
  .cmd_ready   (cmd_ready),
  .cmd_ret     (cmd_ret),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_illegal (rsp_illegal),
  .rsp_pc      (rsp_pc),
  .rsp_pst     (rsp_pst),
  .trap_lvl    (trap_lvl),
  .err_state   (err_state)
);

// File: tb/trap_state_stack_tb.sv
`timescale 1ns/1ps
module trap_state_stack_tb;
  localparam int MAX = 4;
  localparam int PW  = 32;
  localparam int TLW = $clog2(MAX + 1);

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_ret = 0, cmd_retry = 0, rsp_ready = 1;
  logic [8:0] cmd_tt = 0;
  logic [7:0] cur_ccr = 0, cur_asi = 0, cur_cwp = 0;
  logic [11:0] cur_pst = 0;
  logic [PW-1:0] cur_pc = 0, cur_npc = 0;
  logic [PW-16:0] tba_base = 17'h1a5c3;
  logic cmd_ready, rsp_valid, rsp_illegal, err_state;
  logic [PW-1:0] rsp_pc, rsp_npc;
  logic [7:0] rsp_ccr, rsp_asi, rsp_cwp;
  logic [11:0] rsp_pst;
  logic [TLW-1:0] trap_lvl;
  logic [14:0] tba_low;
  logic [8:0] top_tt;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model of what was pushed per level
  logic [7:0]  m_ccr [MAX], m_asi [MAX], m_cwp [MAX];
  logic [11:0] m_pst [MAX];
  logic [PW-1:0] m_pc [MAX], m_npc [MAX];
  logic [8:0]  m_tt [MAX];

  always #10 clk = ~clk;

  trap_state_stack #(.MAX_LVL(MAX), .PC_W(PW)) u_dut (.*);

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one command at a negedge; returns at the following negedge
  task automatic issue(bit ret, bit retry, logic [8:0] tt, int seed);
    cmd_ret = ret; cmd_retry = retry; cmd_tt = tt;
    cur_ccr = 8'(seed * 37 + 5);  cur_asi = 8'(seed * 11 + 128);
    cur_pst = 12'(seed * 291 + 7); cur_cwp = 8'(seed * 3 + 1);
    cur_pc  = 32'h4000_0000 + 32'(seed * 64);
    cur_npc = cur_pc + 32'd4;
    cmd_valid = 1;
    @(posedge clk); @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic push(int seed, logic [8:0] tt);
    int l = int'(trap_lvl);
    logic [14:0] exp_low;
    issue(0, 0, tt, seed);
    m_ccr[l] = cur_ccr; m_asi[l] = cur_asi; m_pst[l] = cur_pst; m_cwp[l] = cur_cwp;
    m_pc[l] = cur_pc; m_npc[l] = cur_npc; m_tt[l] = tt;
    exp_low = {(l > 1), tt, 5'b0};
    check("R5 level", 64'(trap_lvl), 64'(l + 1));
    check("R4 tba_low", 64'(tba_low), 64'(exp_low));
    check("R4 pc", 64'(rsp_pc), 64'({tba_base, exp_low}));
    check("R4 npc", 64'(rsp_npc), 64'({tba_base, exp_low} + 32'd4));
    check("R3 pst", 64'(rsp_pst), (l == MAX - 1) ? 64'h035 : 64'h015);
    check("R3 passthrough", 64'({rsp_ccr, rsp_asi, rsp_cwp}), 64'({cur_ccr, cur_asi, cur_cwp}));
    check("R11 top_tt", 64'(top_tt), 64'(tt));
  endtask

  task automatic pop(bit retry);
    int l = int'(trap_lvl) - 1;
    issue(1, retry, 9'h0, 99);
    check("R7 R8 level", 64'(trap_lvl), 64'(l));
    check("R2 restore", 64'({rsp_ccr, rsp_asi, rsp_pst, rsp_cwp}),
          64'({m_ccr[l], m_asi[l], m_pst[l], m_cwp[l]}));
    if (retry) begin
      check("R8 pc", 64'(rsp_pc), 64'(m_pc[l]));
      check("R8 npc", 64'(rsp_npc), 64'(m_npc[l]));
    end else begin
      check("R7 pc", 64'(rsp_pc), 64'(m_npc[l]));
      check("R7 npc", 64'(rsp_npc), 64'(m_npc[l] + 32'd4));
    end
    check("R11 top_tt", 64'(top_tt), (l == 0) ? 64'h0 : 64'(m_tt[l-1]));
  endtask

  task automatic t_reset();
    check("R1 level", 64'(trap_lvl), 0);
    check("R1 err", 64'(err_state), 0);
    check("R1 rsp_valid", 64'(rsp_valid), 0);
    check("R1 tba_low", 64'(tba_low), 0);
    check("R1 top_tt", 64'(top_tt), 0);
    check("R1 cmd_ready", 64'(cmd_ready), 1);
  endtask

  task automatic t_illegal();
    issue(1, 0, 0, 1);
    check("R9 illegal", 64'(rsp_illegal), 1);
    check("R9 valid", 64'(rsp_valid), 1);
    check("R9 level", 64'(trap_lvl), 0);
  endtask

  task automatic t_nest_unwind();
    push(1, 9'h041); push(2, 9'h1ff); push(3, 9'h024); push(4, 9'h100);
    pop(1); pop(0); pop(0); pop(1);
    check("R9 after unwind ok", 64'(rsp_illegal), 0);
  endtask

  task automatic t_backpressure();
    logic [PW-1:0] held;
    rsp_ready = 0;
    push(5, 9'h0a5);
    held = rsp_pc;
    check("R10 ready low", 64'(cmd_ready), 0);
    cmd_ret = 1; cmd_valid = 1;
    repeat (3) @(negedge clk);
    cmd_valid = 0;
    check("R10 held valid", 64'(rsp_valid), 1);
    check("R10 held pc", 64'(rsp_pc), 64'(held));
    check("R10 level", 64'(trap_lvl), 1);
    rsp_ready = 1;
    @(negedge clk);
    check("R10 drained", 64'(rsp_valid), 0);
    pop(0);
  endtask

  task automatic t_overflow();
    push(6, 9'h011); push(7, 9'h012); push(8, 9'h013); push(9, 9'h014);
    @(negedge clk);
    issue(0, 0, 9'h015, 10);
    check("R6 err", 64'(err_state), 1);
    check("R6 level", 64'(trap_lvl), MAX);
    check("R6 no rsp", 64'(rsp_valid), 0);
    check("R6 ready", 64'(cmd_ready), 0);
    cmd_ret = 1; cmd_valid = 1;
    repeat (2) @(negedge clk);
    cmd_valid = 0;
    check("R6 level frozen", 64'(trap_lvl), MAX);
    check("R6 err sticky", 64'(err_state), 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_illegal();
    @(negedge clk);
    t_nest_unwind();
    @(negedge clk);
    t_backpressure();
    @(negedge clk);
    t_overflow();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule